// File: doc/BRIEF.md
# Paired Capture/Compare Timer

This block holds a 16-bit up-counter and two capture/compare channels that work as a pair: channel 0 (even) and channel 1 (odd). The counter counts up by one each clock while it runs and returns to zero after it reaches a programmable modulo value. Each channel has a control word and a 16-bit value register. A channel either leaves its pin to the GPIO fallback value, latches the counter on edges of its input, or drives its pin on compare matches. Channel 0 can also take over both value registers and run the pair as a double-buffered compare/PWM unit.

Software reaches the block through a simple register bus. The bus has a write strobe, a read strobe, a 3-bit address and 16-bit data, and reads are combinational. Addresses: 0 timer control (bit 0 halt, reads back; bit 1 writes a counter clear and reads 0), 1 modulo, 2 counter (read only), 3 channel 0 control, 4 channel 0 value, 5 channel 1 control, 6 channel 1 value. Control word layout: bit 0 flag, bit 1 interrupt enable, bit 2 mode B (even channel only; reads 0 on channel 1), bit 3 mode A, bits 5:4 action code.

Top module: `ptm_pair`

## Requirements
- R1: While halt is 0 the counter rises by one per clock and goes from the modulo value back to 0. While halt is 1 it holds its value. Writing 1 to timer-control bit 1 sets it to 0.
- R2: With action code 00, or on channel 1 while channel 0 has mode B set, the channel pin equals its GPIO fallback input.
- R3: With mode A = 0, mode B = 0 and a nonzero action code, the channel latches the counter on edges of its input. Code 01 latches on rising edges, 10 on falling edges and 11 on both. The input passes through two flops before edge detection, so the value latched is the count two cycles after the input changes.
- R4: With mode A = 1 and a nonzero action code, each match of the running counter with the value register acts on the pin in the following cycle: 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R5: A channel in compare mode starts from the level preset while its action code was 00: mode A = 1 gives low, mode A = 0 gives high.
- R6: When channel 0 has mode B = 1 and a nonzero action code, it compares against channel 0's value register first. It then swaps between the two value registers at each counter wrap, using the R4 action codes.
- R7: While channel 0's mode B is 1, channel 1 raises no flag and no interrupt, whatever its control word holds.
- R8: A capture or compare match sets the channel flag. Writing 1 to the flag has no effect.
- R9: A write of 0 to the flag clears it only if the previous control access was a read that saw the flag set. Otherwise the flag stays set.
- R10: A channel interrupt output is high exactly while its flag and its enable bit are both 1.
- R11: Mode A and mode B take a write only while halt is 1 and the counter is 0. At other times they keep their value, while the rest of the control word still takes the write.
- R12: After reset halt is 1, modulo is 0xFFFF, the counter, control words and value registers are 0, and the interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| cap_in | input | 2 | Capture inputs, one per channel |
| gpio_fb | input | 2 | GPIO fallback levels for the pins |
| ch_out | output | 2 | Channel pin outputs |
| irq | output | 2 | Channel interrupt requests |

## Verification
The counter runs against a small modulo for more than two full periods. Each cycle is checked against a count that the bench derives arithmetically, which separates off-by-one wrap points from correct ones. The unbuffered compare sweep covers all three action codes against match values at 0, mid-range and the modulo value itself, which shows whether matches are missed at the wrap boundaries. The capture sweep applies one rising and one falling edge per action code, so the latched value tells edge selection and synchronizer delay apart. The buffered runs use distinct even and odd compare values with an active odd control word, so the waveform shows whether the buffer swaps on wrap and whether the odd channel is really ignored.

// File: rtl/ptm_pkg.sv
// Shared constants for the paired capture/compare timer.
// Assumes a 3-bit register address and a 6-bit control word in the low bits.
package ptm_pkg;
    localparam logic [2:0] A_TCTL = 3'd0;
    localparam logic [2:0] A_MOD  = 3'd1;
    localparam logic [2:0] A_CNT  = 3'd2;
    localparam logic [2:0] A_CH0C = 3'd3;
    localparam int         CH_STRIDE = 2;

    localparam int F_FLAG = 0;
    localparam int F_IE   = 1;
    localparam int F_MB   = 2;
    localparam int F_MA   = 3;
    localparam int F_ACT  = 4;

    localparam logic [1:0] ACT_OFF = 2'b00;
    localparam logic [1:0] ACT_TGL = 2'b01;
    localparam logic [1:0] ACT_CLR = 2'b10;
    localparam logic [1:0] ACT_SET = 2'b11;

    typedef enum logic [1:0] {CM_PORT, CM_CAPTURE, CM_COMPARE} chan_mode_e;
endpackage

// File: rtl/ptm_counter.sv
// Free-running up-counter with modulo wrap.
// Assumes halt and clr come from registered control; wrap is a combinational pulse.
module ptm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic          clr,
    input  logic [CW-1:0] modulo,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    // wrap fires in the cycle the running counter sits on the modulo value
    assign wrap = !halt && !clr && (cnt == modulo);

    // count, clear or hold
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (wrap)    cnt <= '0;
        else if (!halt)   cnt <= cnt + 1'b1;
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !clr && cnt != modulo) |=> cnt == CW'($past(cnt) + 1'b1));
    a_r1_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(cnt));
endmodule

// File: rtl/ptm_edge_sync.sv
// Synchronizes an asynchronous input and flags its rising and falling edges.
// Assumes the input idles low out of reset.
module ptm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    // shift chain: STAGES synchronizer flops plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ptm_channel.sv
// One capture/compare channel: control word, value register, pin level and flag.
// Assumes cmp_val is chosen by the parent (buffered pairing) and run marks counting cycles.
module ptm_channel
    import ptm_pkg::*;
#(
    parameter int CW    = 16,
    parameter bit HAS_B = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ok,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp_val,
    input  logic          ctrl_we,
    input  logic          ctrl_re,
    input  logic          val_we,
    input  logic [CW-1:0] wdata,
    input  logic          cap_in,
    input  logic          gpio,
    input  logic          ignore,
    output logic [CW-1:0] ctrl_rd,
    output logic [CW-1:0] val_q,
    output logic          pin,
    output logic          irq
);
    logic       flag_q, ie_q, ma_q, mb_q, arm_q, lvl_q;
    logic [1:0] act_q;
    logic       rise, fall, cap_hit, cmp_hit;
    chan_mode_e mode;

    ptm_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise), .fall(fall)
    );

    // mode B register exists only on the even channel
    generate
        if (HAS_B) begin : g_mb
            always_ff @(posedge clk) begin
                if (!rst_n)                mb_q <= 1'b0;
                else if (ctrl_we && cfg_ok) mb_q <= wdata[F_MB];
            end
        end else begin : g_nomb
            assign mb_q = 1'b0;
        end
    endgenerate

    // decode the operating mode from the control word
    always_comb begin
        if (ignore || act_q == ACT_OFF) mode = CM_PORT;
        else if (ma_q || mb_q)          mode = CM_COMPARE;
        else                            mode = CM_CAPTURE;
    end

    assign cmp_hit = (mode == CM_COMPARE) && run && (cnt == cmp_val);
    assign cap_hit = (mode == CM_CAPTURE) && ((act_q[0] && rise) || (act_q[1] && fall));

    // control fields: enable and action always writable, mode A only when configuration is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            ma_q  <= 1'b0;
            act_q <= ACT_OFF;
        end else if (ctrl_we) begin
            ie_q  <= wdata[F_IE];
            act_q <= wdata[F_ACT +: 2];
            if (cfg_ok) ma_q <= wdata[F_MA];
        end
    end

    // clear-arm: set by a read that sees the flag, dropped by any control write
    always_ff @(posedge clk) begin
        if (!rst_n)                 arm_q <= 1'b0;
        else if (ctrl_we)           arm_q <= 1'b0;
        else if (ctrl_re && flag_q) arm_q <= 1'b1;
    end

    // event flag: events win over the software clear
    always_ff @(posedge clk) begin
        if (!rst_n)                                flag_q <= 1'b0;
        else if (cap_hit || cmp_hit)               flag_q <= 1'b1;
        else if (ctrl_we && arm_q && !wdata[F_FLAG]) flag_q <= 1'b0;
    end

    // pin level: preset while in port control, act on compare matches otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)              lvl_q <= 1'b1;
        else if (mode == CM_PORT) lvl_q <= ~ma_q;
        else if (cmp_hit) begin
            case (act_q)
                ACT_TGL: lvl_q <= ~lvl_q;
                ACT_CLR: lvl_q <= 1'b0;
                ACT_SET: lvl_q <= 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // value register: capture has priority over a bus write
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (cap_hit) val_q <= cnt;
        else if (val_we)  val_q <= wdata;
    end

    // read-back of the control word
    always_comb begin
        ctrl_rd               = '0;
        ctrl_rd[F_FLAG]       = flag_q;
        ctrl_rd[F_IE]         = ie_q;
        ctrl_rd[F_MB]         = mb_q;
        ctrl_rd[F_MA]         = ma_q;
        ctrl_rd[F_ACT +: 2]   = act_q;
    end

    assign pin = (mode == CM_COMPARE) ? lvl_q : gpio;
    assign irq = flag_q && ie_q && !ignore;

    a_r9_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(arm_q));
    a_r8_flag_from_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cap_hit || cmp_hit));
    a_r11_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> (ma_q == $past(ma_q)) && (mb_q == $past(mb_q)));
endmodule

// File: rtl/ptm_pair.sv
// Paired capture/compare timer top: bus decode, counter, buffer select and two channels.
// Assumes a single-cycle register bus with combinational read data.
module ptm_pair
    import ptm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic [1:0]    cap_in,
    input  logic [1:0]    gpio_fb,
    output logic [1:0]    ch_out,
    output logic [1:0]    irq
);
    localparam int NCH = 2;

    logic          halt_q, sel_q, clr, wrap, cfg_ok, mb0, buf_run;
    logic [CW-1:0] mod_q, cnt;
    logic [CW-1:0] ctrl_rd [NCH];
    logic [CW-1:0] val_rd  [NCH];

    assign clr    = bus_wr && (bus_addr == A_TCTL) && bus_wdata[1];
    assign cfg_ok = halt_q && (cnt == '0);
    assign mb0    = ctrl_rd[0][F_MB];
    assign buf_run = mb0 && (ctrl_rd[0][F_ACT +: 2] != ACT_OFF);

    // timer control and modulo registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
            mod_q  <= '1;
        end else if (bus_wr) begin
            if (bus_addr == A_TCTL) halt_q <= bus_wdata[0];
            if (bus_addr == A_MOD)  mod_q  <= bus_wdata;
        end
    end

    ptm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .halt(halt_q), .clr(clr),
        .modulo(mod_q), .cnt(cnt), .wrap(wrap)
    );

    // buffered compare select: starts on the even register, swaps at each wrap
    always_ff @(posedge clk) begin
        if (!rst_n)               sel_q <= 1'b0;
        else if (clr || !buf_run) sel_q <= 1'b0;
        else if (wrap)            sel_q <= ~sel_q;
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            localparam logic [2:0] CA = A_CH0C + 3'(CH_STRIDE * i);
            logic [CW-1:0] cmp_sel;
            assign cmp_sel = (i == 0 && buf_run && sel_q) ? val_rd[1] : val_rd[i];
            ptm_channel #(.CW(CW), .HAS_B(i % 2 == 0)) u_ch (
                .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .run(!halt_q),
                .cnt(cnt), .cmp_val(cmp_sel),
                .ctrl_we(bus_wr && bus_addr == CA),
                .ctrl_re(bus_rd && bus_addr == CA),
                .val_we(bus_wr && bus_addr == CA + 3'd1),
                .wdata(bus_wdata), .cap_in(cap_in[i]), .gpio(gpio_fb[i]),
                .ignore((i % 2 == 1) ? mb0 : 1'b0),
                .ctrl_rd(ctrl_rd[i]), .val_q(val_rd[i]),
                .pin(ch_out[i]), .irq(irq[i])
            );
        end
    endgenerate

    // combinational read mux
    always_comb begin
        case (bus_addr)
            3'd0:    bus_rdata = CW'(halt_q);
            3'd1:    bus_rdata = mod_q;
            3'd2:    bus_rdata = cnt;
            3'd3:    bus_rdata = ctrl_rd[0];
            3'd4:    bus_rdata = val_rd[0];
            3'd5:    bus_rdata = ctrl_rd[1];
            3'd6:    bus_rdata = val_rd[1];
            default: bus_rdata = '0;
        endcase
    end

    a_r7_odd_released: assert property (@(posedge clk) disable iff (!rst_n)
        mb0 |-> (ch_out[1] == gpio_fb[1]) && !irq[1]);
endmodule

// File: tb/ptm_pair_test.sv
module ptm_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [1:0]  cap_in = 2'b00, fb = 2'b00;
    logic [1:0]  ch_out, irq;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptm_pair uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .gpio_fb(fb), .ch_out(ch_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] cw(input bit mb, input bit ma, input logic [1:0] act, input bit ie);
        return {10'd0, act, ma, mb, ie, 1'b0};
    endfunction

    task automatic stop_clear();
        wr(3'd0, 16'h0003);
    endtask

    task automatic clr_flag(input logic [2:0] ca);
        logic [15:0] d;
        rd(ca, d);
        wr(ca, d & 16'hFFFE);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, c, expv;
        int e_cnt, v, m;
        bit e_lvl, e_sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(3'd0, d); chk("R12 halt", d, 16'h0001);
        rd(3'd1, d); chk("R12 modulo", d, 16'hFFFF);
        rd(3'd2, d); chk("R12 count", d, 16'h0000);
        rd(3'd3, d); chk("R12 ch0 ctrl", d, 16'h0000);
        rd(3'd5, d); chk("R12 ch1 ctrl", d, 16'h0000);
        rd(3'd4, d); chk("R12 ch0 value", d, 16'h0000);
        chk("R12 irq", {14'd0, irq}, 16'h0000);

        // R2 port control follows the fallback
        for (int k = 0; k < 4; k++) begin
            fb = 2'(k);
            #1 chk("R2 port pins", {14'd0, ch_out}, {14'd0, 2'(k)});
            @(negedge clk);
        end

        // R1 counter sweep with modulo 9
        stop_clear(); wr(3'd1, 16'd9); wr(3'd0, 16'd0);
        bus_addr = 3'd2;
        for (int k = 0; k < 25; k++) begin
            #1 chk("R1 count", bus_rdata, 16'(k % 10));
            @(negedge clk);
        end
        wr(3'd0, 16'd1);
        rd(3'd2, c); rd(3'd2, d); chk("R1 halted hold", d, c);
        stop_clear(); rd(3'd2, d); chk("R1 clear", d, 16'd0);

        // R11 mode lock
        wr(3'd0, 16'd0); repeat (3) @(negedge clk);
        wr(3'd3, cw(0, 1, 2'b01, 0));
        rd(3'd3, d); chk("R11 locked while running", d, 16'h0010);
        wr(3'd0, 16'd1);
        wr(3'd3, cw(0, 1, 2'b01, 0));
        rd(3'd3, d); chk("R11 locked halted nonzero", d, 16'h0010);
        stop_clear();
        wr(3'd3, cw(0, 1, 2'b01, 0));
        rd(3'd3, d); chk("R11 open halted zero", d, 16'h0018);

        // R4/R5 unbuffered compare sweep
        m = 15;
        for (int a = 1; a < 4; a++) begin
            for (int vi = 0; vi < 3; vi++) begin
                v = (vi == 0) ? 0 : (vi == 1) ? 5 : m;
                stop_clear(); wr(3'd1, 16'(m));
                wr(3'd3, cw(0, 1, 2'b00, 0));
                wr(3'd4, 16'(v));
                wr(3'd3, cw(0, 1, 2'(a), 0));
                #1 chk("R5 preset low", {15'd0, ch_out[0]}, 16'd0);
                wr(3'd0, 16'd0);
                e_cnt = 0; e_lvl = 1'b0;
                for (int k = 0; k < 40; k++) begin
                    #1 chk("R4 compare pin", {15'd0, ch_out[0]}, {15'd0, e_lvl});
                    if (e_cnt == v) e_lvl = (a == 1) ? ~e_lvl : (a == 3);
                    e_cnt = (e_cnt == m) ? 0 : e_cnt + 1;
                    @(negedge clk);
                end
                rd(3'd3, d); chk("R8 flag set on match", {15'd0, d[0]}, 16'd1);
            end
        end

        // R8/R9/R10 flag handling (ch0 word is 0x38 plus flag)
        wr(3'd0, 16'd1);
        rd(3'd3, d); chk("R8 flag before clear", {15'd0, d[0]}, 16'd1);
        wr(3'd3, 16'h0039);
        #1 chk("R10 irq off when disabled", {15'd0, irq[0]}, 16'd0);
        wr(3'd3, 16'h0038);
        rd(3'd3, d); chk("R9 unarmed write keeps flag", {15'd0, d[0]}, 16'd1);
        wr(3'd3, 16'h003B);
        #1 chk("R10 irq with flag and enable", {15'd0, irq[0]}, 16'd1);
        rd(3'd3, d); chk("R8 write one no effect", {15'd0, d[0]}, 16'd1);
        wr(3'd3, 16'h003A);
        #1 chk("R10 irq drops after clear", {15'd0, irq[0]}, 16'd0);
        rd(3'd3, d); chk("R9 armed clear", {15'd0, d[0]}, 16'd0);
        wr(3'd3, 16'h003B);
        rd(3'd3, d); chk("R8 write one keeps clear", {15'd0, d[0]}, 16'd0);

        // R3 capture sweep
        for (int a = 1; a < 4; a++) begin
            stop_clear(); wr(3'd1, 16'hFFFF);
            wr(3'd3, cw(0, 0, 2'(a), 0));
            wr(3'd4, 16'h1234);
            clr_flag(3'd3);
            expv = 16'h1234;
            wr(3'd0, 16'd0);
            repeat (3) @(negedge clk);
            bus_addr = 3'd2; #1 c = bus_rdata; cap_in[0] = 1'b1;
            if (a[0]) expv = c + 16'd2;
            repeat (5) @(negedge clk);
            rd(3'd4, d); chk("R3 rising edge capture", d, expv);
            bus_addr = 3'd2; #1 c = bus_rdata; cap_in[0] = 1'b0;
            if (a[1]) expv = c + 16'd2;
            repeat (5) @(negedge clk);
            rd(3'd4, d); chk("R3 falling edge capture", d, expv);
            rd(3'd3, d); chk("R8 flag set on capture", {15'd0, d[0]}, 16'd1);
        end

        // R6/R7 buffered pairing, toggle and clear actions
        for (int a = 1; a < 3; a++) begin
            stop_clear(); wr(3'd1, 16'd7);
            wr(3'd3, cw(1, 0, 2'b00, 0));
            wr(3'd4, 16'd2); wr(3'd6, 16'd5);
            wr(3'd5, cw(0, 1, 2'b11, 1));
            wr(3'd3, cw(1, 0, 2'(a), 0));
            #1 chk("R5 preset high", {15'd0, ch_out[0]}, 16'd1);
            wr(3'd0, 16'd0);
            e_cnt = 0; e_lvl = 1'b1; e_sel = 1'b0;
            for (int k = 0; k < 32; k++) begin
                #1 chk("R6 buffered pin", {15'd0, ch_out[0]}, {15'd0, e_lvl});
                chk("R7 odd pin is fallback", {15'd0, ch_out[1]}, {15'd0, fb[1]});
                chk("R7 odd irq quiet", {15'd0, irq[1]}, 16'd0);
                if (e_cnt == (e_sel ? 5 : 2)) e_lvl = (a == 1) ? ~e_lvl : 1'b0;
                if (e_cnt == 7) e_sel = ~e_sel;
                e_cnt = (e_cnt == 7) ? 0 : e_cnt + 1;
                fb[1] = ~fb[1];
                @(negedge clk);
            end
            rd(3'd5, d); chk("R7 odd flag never set", {15'd0, d[0]}, 16'd0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule